// File: doc/BRIEF.md
# Step Attenuator Control Interface

This block is the digital front end of a 7-bit step attenuator. It accepts a mode pin, seven parallel code pins and a three-wire serial port (data, shift clock, latch strobe). From these it keeps one registered 7-bit attenuation code for the attenuator core. The code counts quarter-dB steps, so code 50 means 12.5 dB and code 127 means 31.75 dB. All pins are asynchronous to the block. They are brought into a reference clock domain through two-flop synchronizers, and every serial clock and latch edge is detected in that domain.

Three ways of loading the code share the one output register. In serial mode, an 8-bit word is shifted in with the least significant bit first and applied by a latch strobe. In latched-parallel mode, the pins are captured on the falling edge of a high pulse on the strobe. In direct-parallel mode, the strobe is held high and the code follows the pins. After reset the code sits at maximum attenuation. In direct mode, maximum attenuation is also forced until a power-up delay has run out. The delay is 400 µs of reference clock, set by parameters. A serial word with its top bit set raises an error flag, and its lower seven bits are still applied.

Top module: `step_atten_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, before any latch event, `code_o` is 127 (maximum attenuation) and `word_err_o` is 0.
- R2: With `mode_sel_i`=1 (serial), each rising edge of `sclk_i` while `latch_i` is low shifts `sdata_i` into an 8-bit word, with the first bit sent ending in bit 0. A rising edge of `latch_i` loads word bits 6..0 into `code_o`.
- R3: In serial mode, rising edges of `sclk_i` while `latch_i` is high do not change the shift word. A later latch applies the earlier word.
- R4: On a serial latch, `word_err_o` takes the value of word bit 7. The code still takes bits 6..0.
- R5: With `mode_sel_i`=0 and `latch_i` low, pin changes on `par_i` leave `code_o` unchanged. A falling edge of `latch_i` loads `par_i` into `code_o`.
- R6: With `mode_sel_i`=0, `latch_i` high and the power-up delay done, `code_o` follows `par_i`.
- R7: `pup_done_o` is low for DELAY_US microseconds of reference clock after reset and then stays high. In direct mode before that point, `code_o` is 127 whatever `par_i` holds.
- R8: In serial mode, `par_i` has no effect on `code_o`.
- R9: When a serial clock rising edge and a latch rising edge reach the block in the same reference cycle, the clock edge does not shift. The word is latched as it stood before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_sel_i | input | 1 | 1 = serial, 0 = parallel |
| par_i | input | 7 | Parallel attenuation code pins |
| sdata_i | input | 1 | Serial data |
| sclk_i | input | 1 | Serial shift clock |
| latch_i | input | 1 | Latch strobe; held high for direct parallel mode |
| code_o | output | 7 | Registered attenuation code, quarter-dB steps |
| pup_done_o | output | 1 | Power-up delay has elapsed |
| word_err_o | output | 1 | Last latched serial word had bit 7 set |

## Verification
Two events can meet in one reference cycle: a serial clock rise and a latch rise. The first shifts the word and the second applies it. The bench provokes the overlap by raising `sclk_i` and `latch_i` together, after a word has been shifted in only in part, with a set data bit on the pin. The expected code and error flag are worked out from the unshifted word, and they differ from the values an extra shift would give. The run also holds direct mode across the moment the power-up delay runs out. The output is checked once before and once after that point.

// File: rtl/atten_pkg.sv
package atten_pkg;
  localparam int CODE_W = 7;
  localparam int WORD_W = CODE_W + 1;
  typedef logic [CODE_W-1:0] code_t;
  typedef enum logic {MODE_PAR = 1'b0, MODE_SER = 1'b1} mode_e;
  localparam code_t CODE_MAX = {CODE_W{1'b1}};
endpackage

// File: rtl/atten_sync.sv
module atten_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/atten_shift.sv
module atten_shift #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              sck_rise_i,
  input  logic              le_lvl_i,
  input  logic              sd_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] word_d;
  logic              shift_en;

  assign shift_en = en_i & sck_rise_i & ~le_lvl_i;

  always_comb begin
    word_d = word_q;
    if (shift_en) word_d = {sd_i, word_q[WORD_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign word_o = word_q;

  // R3: a clock edge while the latch strobe is high leaves the word alone
  assert_no_shift_le_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_rise_i && le_lvl_i) |=> $stable(word_q));
endmodule

// File: rtl/atten_pup_timer.sv
module atten_pup_timer #(
  parameter int LIMIT = 20000
) (
  input  logic clk,
  input  logic rst_n,
  output logic done_o
);
  localparam int CNT_W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (!done_q) begin
      if (cnt_q == CNT_W'(LIMIT - 1)) done_d = 1'b1;
      else                           cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;

  // R7: once the delay is over it stays over
  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> done_q);
  // R7: the count never passes its limit while waiting
  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> (cnt_q < CNT_W'(LIMIT)));
endmodule

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl
  import atten_pkg::*;
#(
  parameter int CLK_HZ   = 50_000_000,
  parameter int DELAY_US = 400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_sel_i,
  input  logic [CODE_W-1:0] par_i,
  input  logic              sdata_i,
  input  logic              sclk_i,
  input  logic              latch_i,
  output logic [CODE_W-1:0] code_o,
  output logic              pup_done_o,
  output logic              word_err_o
);
  localparam int IN_W      = CODE_W + 4;
  localparam int DLY_RAW   = ((CLK_HZ / 1000) * DELAY_US) / 1000;
  localparam int DLY_LIMIT = (DLY_RAW < 1) ? 1 : DLY_RAW;

  logic [IN_W-1:0]   pins_raw, pins_s;
  mode_e             mode_s;
  logic              le_s, sck_s, sd_s;
  code_t             par_s;
  logic              sck_q, le_q;
  logic              sck_rise, le_rise, le_fall;
  logic [WORD_W-1:0] word;
  logic              pup_done;
  code_t             code_q, code_d;
  logic              err_q, err_d;

  assign pins_raw = {mode_sel_i, latch_i, sclk_i, sdata_i, par_i};

  atten_sync #(.W(IN_W)) i_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pins_raw), .q_o(pins_s)
  );

  assign mode_s = mode_e'(pins_s[IN_W-1]);
  assign le_s   = pins_s[IN_W-2];
  assign sck_s  = pins_s[IN_W-3];
  assign sd_s   = pins_s[IN_W-4];
  assign par_s  = pins_s[CODE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      le_q  <= 1'b0;
    end else begin
      sck_q <= sck_s;
      le_q  <= le_s;
    end
  end

  assign sck_rise = sck_s & ~sck_q;
  assign le_rise  = le_s & ~le_q;
  assign le_fall  = ~le_s & le_q;

  atten_shift #(.WORD_W(WORD_W)) i_shift (
    .clk(clk), .rst_n(rst_n), .en_i(mode_s == MODE_SER),
    .sck_rise_i(sck_rise), .le_lvl_i(le_s), .sd_i(sd_s), .word_o(word)
  );

  atten_pup_timer #(.LIMIT(DLY_LIMIT)) i_timer (
    .clk(clk), .rst_n(rst_n), .done_o(pup_done)
  );

  always_comb begin
    code_d = code_q;
    err_d  = err_q;
    if (mode_s == MODE_SER) begin
      if (le_rise) begin
        code_d = word[CODE_W-1:0];
        err_d  = word[WORD_W-1];
      end
    end else if (le_s) begin
      code_d = pup_done ? par_s : CODE_MAX;
    end else if (le_fall) begin
      code_d = par_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= CODE_MAX;
      err_q  <= 1'b0;
    end else begin
      code_q <= code_d;
      err_q  <= err_d;
    end
  end

  assign code_o     = code_q;
  assign pup_done_o = pup_done;
  assign word_err_o = err_q;

  // R8: in serial mode only a latch edge moves the code
  assert_serial_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_s == MODE_SER && !le_rise) |=> $stable(code_q));
  // R4: error flag mirrors bit 7 of the word that was latched
  assert_err_tracks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_s == MODE_SER && le_rise) |=> (err_q == $past(word[WORD_W-1])));
  // R7: direct mode before the delay ends pins the code at maximum
  assert_direct_max_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_s == MODE_PAR && le_s && !pup_done) |=> (code_q == CODE_MAX));
  // R5: latched parallel with strobe low and no falling edge holds the code
  assert_latched_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_s == MODE_PAR && !le_s && !le_fall) |=> $stable(code_q));
endmodule

// File: tb/test_step_atten_ctrl.sv
module test_step_atten_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int TB_HZ      = 100_000;

  typedef struct {
    logic [6:0] code;
    logic       err;
    logic       done;
    logic       chk_done;
    string      req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_sel, sdata, sclk, latch;
  logic [6:0] par;
  logic [6:0] code;
  logic       pup_done, word_err;

  int   n_vec  = 0;
  int   n_fail = 0;
  exp_t sb_q[$];
  bit   finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  step_atten_ctrl #(.CLK_HZ(TB_HZ), .DELAY_US(400)) i_step_atten_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_sel_i(mode_sel), .par_i(par),
    .sdata_i(sdata), .sclk_i(sclk), .latch_i(latch),
    .code_o(code), .pup_done_o(pup_done), .word_err_o(word_err)
  );

  // monitor: pops expected items and compares away from the rising edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_vec++;
      if (code !== e.code || word_err !== e.err ||
          (e.chk_done && pup_done !== e.done)) begin
        n_fail++;
        $display("FAIL %s: code=%0d err=%0b done=%0b expected code=%0d err=%0b done=%0b",
                 e.req, code, word_err, pup_done, e.code, e.err, e.done);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic expect_out(input logic [6:0] c, input logic e, input logic d,
                            input logic cd, input string req);
    exp_t x;
    tick(6);
    x.code = c; x.err = e; x.done = d; x.chk_done = cd; x.req = req;
    sb_q.push_back(x);
    @(negedge clk);
    tick(1);
  endtask

  task automatic do_reset(input logic m, input logic le, input logic [6:0] p);
    rst_n = 1'b0; mode_sel = m; latch = le; par = p; sdata = 0; sclk = 0;
    tick(3);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic shift_bits(input logic [7:0] w, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      sdata = w[i]; tick(3);
      sclk = 1'b1;  tick(3);
      sclk = 1'b0;  tick(3);
    end
  endtask

  task automatic send_word(input logic [7:0] w);
    shift_bits(w, 8);
    latch = 1'b1; tick(4);
    latch = 1'b0; tick(4);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state in serial mode
    do_reset(1'b1, 1'b0, 7'd0);
    expect_out(7'd127, 1'b0, 1'b0, 1'b0, "R1");
    // R2: serial word 12.5 dB -> code 50
    send_word(8'h32);
    expect_out(7'd50, 1'b0, 1'b0, 1'b0, "R2");
    send_word(8'h01);
    expect_out(7'd1, 1'b0, 1'b0, 1'b0, "R2");
    // R4: top bit set flags error, low bits applied
    send_word(8'h85);
    expect_out(7'd5, 1'b1, 1'b0, 1'b0, "R4");
    send_word(8'h32);
    expect_out(7'd50, 1'b0, 1'b0, 1'b0, "R4");
    // R3: clocks with strobe high do not shift; re-latch gives same word
    latch = 1'b1; tick(4);
    shift_bits(8'hFF, 8);
    latch = 1'b0; tick(4);
    latch = 1'b1; tick(4);
    latch = 1'b0; tick(4);
    expect_out(7'd50, 1'b0, 1'b0, 1'b0, "R3");
    // R8: parallel pins ignored in serial mode
    par = 7'd99; tick(8);
    expect_out(7'd50, 1'b0, 1'b0, 1'b0, "R8");
    par = 7'd0;
    // R9: clock and latch rise together: no shift, prior word latched
    send_word(8'h00);
    shift_bits(8'h3F, 7);
    sdata = 1'b1; tick(3);
    sclk = 1'b1; latch = 1'b1; tick(4);
    sclk = 1'b0; latch = 1'b0; tick(4);
    expect_out(7'h7E, 1'b0, 1'b0, 1'b0, "R9");

    // R7: direct mode from reset holds maximum until the delay ends
    do_reset(1'b0, 1'b1, 7'd5);
    tick(10);
    expect_out(7'd127, 1'b0, 1'b0, 1'b1, "R7");
    tick(40);
    expect_out(7'd5, 1'b0, 1'b1, 1'b1, "R7");
    // R6: direct mode follows pins
    par = 7'd33;
    expect_out(7'd33, 1'b0, 1'b1, 1'b1, "R6");
    par = 7'd0;
    expect_out(7'd0, 1'b0, 1'b1, 1'b1, "R6");
    // R5: latched parallel; pin changes with strobe low have no effect
    latch = 1'b0; tick(4);
    par = 7'd10;
    expect_out(7'd0, 1'b0, 1'b1, 1'b1, "R5");
    latch = 1'b1; tick(4);
    latch = 1'b0; tick(4);
    expect_out(7'd10, 1'b0, 1'b1, 1'b1, "R5");
    par = 7'd127;
    expect_out(7'd10, 1'b0, 1'b1, 1'b1, "R5");

    tick(4);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule